// File: doc/BRIEF.md
# Serial Masked Vector Reduction Unit

This block folds the elements of one vector register into a single scalar. It can add them, take the signed maximum or take the signed minimum. The fold always starts from a seed scalar, which is element 0 of a second source operand. The final value is offered as the new element 0 of the destination, together with a write enable.

A reduction begins with a one-cycle `start_i` pulse. That pulse carries the operation, the dynamic vector length, the mask-enable flag and the seed. After the start, the source register streams in one element per accepted cycle on `elem_i`. The mask bit for each element arrives beside it on `mask_bit_i`. Exactly `NUM_ELEMS` elements (the register capacity) are streamed, from index 0 upward. Only elements whose index is below the vector length are folded in. When masking is enabled, an element is also dropped if its mask bit is 0.

After the last element is accepted, `done_o` pulses for one cycle. In that cycle `result_o` carries the value and `wr_en_o` says whether element 0 of the destination may be written. A zero vector length completes without touching the destination.

Top module: `vred_unit`

## Requirements
- R1: With operation code 2'b00 the result is the seed plus all active elements, wrapped modulo 2^ELEM_W.
- R2: With operation code 2'b01 the result is the largest of the seed and all active elements, compared as signed two's-complement values.
- R3: With operation code 2'b10 the result is the smallest of the seed and all active elements, compared as signed two's-complement values.
- R4: Only streamed elements with index below the vector length take part. A vector length above NUM_ELEMS is treated as NUM_ELEMS.
- R5: When `mask_en_i` is 1 at start, an element with `mask_bit_i` 0 is excluded. When `mask_en_i` is 0, mask bits have no effect.
- R6: If no element is active but the vector length is non-zero, the result equals the seed and `wr_en_o` is 1.
- R7: A start with vector length 0 raises `done_o` on the next cycle with `wr_en_o` 0, consumes no elements and leaves the unit idle.
- R8: `done_o` is high for exactly one cycle, the cycle after the element with index NUM_ELEMS-1 is accepted. `busy_o` is high from the cycle after the start until that point.
- R9: A `start_i` pulse while the unit is busy is ignored. The running reduction keeps its operation, seed and length.
- R10: After reset `busy_o`, `done_o` and `wr_en_o` are 0.
- R11: Operation code 2'b11 behaves as a sum.
- R12: Cycles with `elem_valid_i` low during a reduction neither advance the element index nor change the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a reduction (accepted only when idle) |
| op_i | input | 2 | Operation: 00 sum, 01 signed max, 10 signed min, 11 sum |
| mask_en_i | input | 1 | Enable per-element masking |
| vlen_i | input | VL_W | Dynamic vector length |
| seed_i | input | ELEM_W | Seed scalar (element 0 of the second source) |
| elem_valid_i | input | 1 | Streamed element present this cycle |
| elem_i | input | ELEM_W | Streamed source element |
| mask_bit_i | input | 1 | Mask bit for the streamed element |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Destination element 0 may be written (only with done_o) |
| result_o | output | ELEM_W | Reduced scalar, valid while wr_en_o is high |

## Verification
Every result is registered once. `done_o`, `wr_en_o` and `result_o` therefore appear in the cycle right after the edge that samples the last element, or after the edge that samples a zero-length start. `busy_o` rises one cycle after the start. The bench drives inputs on the falling edge and reads outputs on the next falling edge. A behavioural model updates on the same rising edges, so each comparison lands on the cycle the output is due. Directed scenarios then check the completion cycle, and the cycle after it, against hand-computed values.

// File: rtl/vred_pkg.sv
package vred_pkg;

    typedef enum logic [1:0] {
        RED_SUM     = 2'b00,
        RED_MAX     = 2'b01,
        RED_MIN     = 2'b10,
        RED_SUM_ALT = 2'b11
    } red_op_e;

endpackage

// File: rtl/vred_combine.sv
module vred_combine
    import vred_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  red_op_e             op_i,
    input  logic [ELEM_W-1:0]   acc_i,
    input  logic [ELEM_W-1:0]   elem_i,
    output logic [ELEM_W-1:0]   res_o
);
    logic [ELEM_W-1:0] sum_w;
    logic              elem_gt_w;
    logic              elem_lt_w;

    always_comb begin
        sum_w     = acc_i + elem_i;
        elem_gt_w = $signed(elem_i) > $signed(acc_i);
        elem_lt_w = $signed(elem_i) < $signed(acc_i);
        unique case (op_i)
            RED_MAX: res_o = elem_gt_w ? elem_i : acc_i;
            RED_MIN: res_o = elem_lt_w ? elem_i : acc_i;
            default: res_o = sum_w;
        endcase
    end
endmodule

// File: rtl/vred_gate.sv
module vred_gate #(
    parameter int NUM_ELEMS = 16,
    parameter int IDX_W     = 4
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W:0]   vl_i,
    input  logic             mask_en_i,
    input  logic             mask_bit_i,
    input  logic             valid_i,
    output logic             take_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEMS - 1);

    logic in_len_w;
    logic mask_ok_w;

    always_comb begin
        in_len_w  = {1'b0, idx_i} < vl_i;
        mask_ok_w = !mask_en_i || mask_bit_i;
        take_o    = valid_i && in_len_w && mask_ok_w;
        last_o    = valid_i && (idx_i == LAST_IDX);
    end
endmodule

// File: rtl/vred_unit.sv
module vred_unit
    import vred_pkg::*;
#(
    parameter int ELEM_W    = 32,
    parameter int NUM_ELEMS = 16,
    parameter int VL_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              mask_en_i,
    input  logic [VL_W-1:0]   vlen_i,
    input  logic [ELEM_W-1:0] seed_i,
    input  logic              elem_valid_i,
    input  logic [ELEM_W-1:0] elem_i,
    input  logic              mask_bit_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              wr_en_o,
    output logic [ELEM_W-1:0] result_o
);
    localparam int IDX_W = (NUM_ELEMS > 1) ? $clog2(NUM_ELEMS) : 1;
    localparam int VLE_W = IDX_W + 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              wr;
        logic              men;
        red_op_e           op;
        logic [IDX_W-1:0]  idx;
        logic [VLE_W-1:0]  vl;
        logic [ELEM_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    logic [31:0]       vlen_ext_w;
    logic [VLE_W-1:0]  vl_clamp_w;
    logic              take_w;
    logic              last_w;
    logic [ELEM_W-1:0] fold_w;

    assign vlen_ext_w = 32'(vlen_i);
    assign vl_clamp_w = (vlen_ext_w > 32'(NUM_ELEMS)) ? VLE_W'(NUM_ELEMS)
                                                      : VLE_W'(vlen_ext_w);

    vred_gate #(
        .NUM_ELEMS (NUM_ELEMS),
        .IDX_W     (IDX_W)
    ) gate_i (
        .idx_i      (st_q.idx),
        .vl_i       (st_q.vl),
        .mask_en_i  (st_q.men),
        .mask_bit_i (mask_bit_i),
        .valid_i    (elem_valid_i && st_q.busy),
        .take_o     (take_w),
        .last_o     (last_w)
    );

    vred_combine #(
        .ELEM_W (ELEM_W)
    ) comb_i (
        .op_i   (st_q.op),
        .acc_i  (st_q.acc),
        .elem_i (elem_i),
        .res_o  (fold_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.wr   = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                if (vl_clamp_w == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.op   = red_op_e'(op_i);
                    st_d.men  = mask_en_i;
                    st_d.vl   = vl_clamp_w;
                    st_d.idx  = '0;
                    st_d.acc  = seed_i;
                end
            end
        end else if (elem_valid_i) begin
            if (take_w) begin
                st_d.acc = fold_w;
            end
            if (last_w) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.wr   = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b0, wr: 1'b0, men: 1'b0,
                      op: RED_SUM, idx: '0, vl: '0, acc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign wr_en_o  = st_q.wr;
    assign result_o = st_q.acc;

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the unit is idle in the completion cycle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7: a write is only offered together with completion
    p_wr_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> done_o);

    // R7: zero length completes at once without a write
    p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && vlen_i == '0) |=> (done_o && !wr_en_o && !busy_o));

    // R9: configuration is frozen while a reduction runs
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(st_q.op) && $stable(st_q.men) && $stable(st_q.vl)));

    // R9: a start without an element cannot end a running reduction
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !elem_valid_i) |=> busy_o);

    // R12: an idle stream cycle leaves index and accumulator alone
    p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !elem_valid_i) |=> ($stable(st_q.idx) && $stable(st_q.acc)));
endmodule

// File: tb/vred_unit_tb_top.sv
module vred_unit_tb_top;
    localparam int W   = 8;
    localparam int NUM = 8;
    localparam int VLW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [1:0]     op_i = 2'b00;
    logic           mask_en_i = 1'b0;
    logic [VLW-1:0] vlen_i = '0;
    logic [W-1:0]   seed_i = '0;
    logic           elem_valid_i = 1'b0;
    logic [W-1:0]   elem_i = '0;
    logic           mask_bit_i = 1'b0;
    logic           busy_o, done_o, wr_en_o;
    logic [W-1:0]   result_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    vred_unit #(.ELEM_W(W), .NUM_ELEMS(NUM), .VL_W(VLW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .mask_en_i(mask_en_i), .vlen_i(vlen_i), .seed_i(seed_i),
        .elem_valid_i(elem_valid_i), .elem_i(elem_i), .mask_bit_i(mask_bit_i),
        .busy_o(busy_o), .done_o(done_o), .wr_en_o(wr_en_o), .result_o(result_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit           m_busy, m_done, m_wr, m_men;
    int           m_idx, m_vl, m_op;
    logic [W-1:0] m_acc;

    function automatic logic [W-1:0] fold(int op, logic [W-1:0] a, logic [W-1:0] e);
        if (op == 1) return ($signed(e) > $signed(a)) ? e : a;
        if (op == 2) return ($signed(e) < $signed(a)) ? e : a;
        return a + e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_wr = 0;
        end else begin
            m_done = 0; m_wr = 0;
            if (!m_busy) begin
                if (start_i) begin
                    if (vlen_i == 0) m_done = 1;
                    else begin
                        m_busy = 1; m_idx = 0; m_acc = seed_i; m_op = op_i;
                        m_men = mask_en_i; m_vl = (vlen_i > NUM) ? NUM : int'(vlen_i);
                    end
                end
            end else if (elem_valid_i) begin
                if (m_idx < m_vl && (!m_men || mask_bit_i)) m_acc = fold(m_op, m_acc, elem_i);
                if (m_idx == NUM - 1) begin
                    m_busy = 0; m_done = 1; m_wr = 1;
                end else m_idx++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 busy vs model", busy_o, m_busy);
            check("R8 done vs model", done_o, m_done);
            check("R7 wr_en vs model", wr_en_o, m_wr);
            if (m_wr) check("R1 result vs model", result_o, m_acc);
        end
    end

    // runs one reduction; stray_start injects a start at element 3 (R9),
    // gaps inserts idle stream cycles before odd elements (R12)
    task automatic run_red(input string tag, input logic [1:0] op, input bit men,
                           input int vl, input logic [W-1:0] seed,
                           input logic [NUM*W-1:0] elems, input logic [NUM-1:0] masks,
                           input bit stray_start, input bit gaps,
                           input logic [W-1:0] exp_res);
        @(negedge clk);
        start_i = 1; op_i = op; mask_en_i = men; vlen_i = VLW'(vl); seed_i = seed;
        @(negedge clk);
        start_i = 0;
        if (vl == 0) begin
            check({tag, " R7 done"}, done_o, 1);
            check({tag, " R7 no write"}, wr_en_o, 0);
            check({tag, " R7 idle"}, busy_o, 0);
            return;
        end
        check({tag, " R8 busy"}, busy_o, 1);
        for (int i = 0; i < NUM; i++) begin
            if (gaps && (i % 2 == 1)) begin
                elem_valid_i = 0; elem_i = 8'hAA; mask_bit_i = 1;
                @(negedge clk);
            end
            elem_valid_i = 1; elem_i = elems[i*W +: W]; mask_bit_i = masks[i];
            if (stray_start && i == 3) begin
                start_i = 1; op_i = 2'b10; seed_i = 8'h80; vlen_i = 5'd1;
            end else start_i = 0;
            @(negedge clk);
        end
        elem_valid_i = 0; start_i = 0;
        check({tag, " R8 done after last"}, done_o, 1);
        check({tag, " wr_en"}, wr_en_o, 1);
        check({tag, " result"}, result_o, exp_res);
        @(negedge clk);
        check({tag, " R8 done one cycle"}, done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 busy after reset", busy_o, 0);
        check("R10 done after reset", done_o, 0);
        check("R10 wr after reset", wr_en_o, 0);
        rst_n = 1;
        // R1 + R9: plain sum 10+36, stray start ignored
        run_red("R1 sum R9 stray", 2'b00, 0, 8, 8'd10,
                {8'd8,8'd7,8'd6,8'd5,8'd4,8'd3,8'd2,8'd1}, 8'h00, 1, 0, 8'd46);
        // R1 + R12: wrap 200+160=360 -> 104, with gaps
        run_red("R1 wrap R12 gaps", 2'b00, 0, 8, 8'd200, {8{8'd20}}, 8'h00, 0, 1, 8'd104);
        // R2: signed max -> 7
        run_red("R2 max", 2'b01, 0, 8, 8'hFB,
                {8'd6,8'd1,8'd0,8'hFF,8'd2,8'd7,8'h9C,8'd3}, 8'h00, 0, 0, 8'd7);
        // R2: seed -2 beats all -10
        run_red("R2 max seed", 2'b01, 0, 8, 8'hFE, {8{8'hF6}}, 8'h00, 0, 0, 8'hFE);
        // R3: signed min -> -128
        run_red("R3 min", 2'b10, 0, 8, 8'd0,
                {8'd4,8'd3,8'd2,8'd1,8'h80,8'd100,8'hFD,8'd5}, 8'h00, 0, 0, 8'h80);
        // R4: vl=3 -> 1+2+4
        run_red("R4 vl3", 2'b00, 0, 3, 8'd0,
                {8'd128,8'd64,8'd32,8'd16,8'd8,8'd4,8'd2,8'd1}, 8'h00, 0, 0, 8'd7);
        // R4: vl=20 clamps to 8 -> 8*31=248
        run_red("R4 clamp", 2'b00, 0, 20, 8'd0, {8{8'd31}}, 8'h00, 0, 0, 8'd248);
        // R5: mask bits 1,3,5,7 -> 2+4+6+8
        run_red("R5 masked", 2'b00, 1, 8, 8'd0,
                {8'd8,8'd7,8'd6,8'd5,8'd4,8'd3,8'd2,8'd1}, 8'hAA, 0, 0, 8'd20);
        // R5: mask disabled -> 36
        run_red("R5 unmasked", 2'b00, 0, 8, 8'd0,
                {8'd8,8'd7,8'd6,8'd5,8'd4,8'd3,8'd2,8'd1}, 8'hAA, 0, 0, 8'd36);
        // R6: all masked, max -> seed 77
        run_red("R6 all masked", 2'b01, 1, 8, 8'd77, {8{8'd120}}, 8'h00, 0, 0, 8'd77);
        // R7: zero length
        run_red("R7 zero", 2'b00, 0, 0, 8'd5, {8{8'd1}}, 8'h00, 0, 0, 8'd0);
        // R11: code 11 sums -> 1+8
        run_red("R11 alt sum", 2'b11, 0, 8, 8'd1, {8{8'd1}}, 8'h00, 0, 0, 8'd9);
        repeat (3) @(negedge clk);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule